// File: doc/BRIEF.md
# Status Register Transfer Unit

This block keeps the processor's live status word together with five banked copies that hold a saved status word, one for each exception mode. It decodes three instruction shapes that move data between those status words and the general registers:

- a read that copies a status word into a general register;
- a full write that copies a general register into a status word;
- a flags-only write whose operand is either a general register or a rotated 8-bit constant.

Each instruction runs in one cycle. It runs only when its 4-bit condition field passes against the live N, Z, C and V flags.

The general register file sits outside the block. The block drives `src_idx` from the instruction word straight away, so the file can return the operand on `src_val` in the same cycle. A read returns its result one cycle after the instruction is accepted, on `rf_we`, `rf_waddr` and `rf_wdata`. The same registered stage raises `illegal` for one cycle when the instruction is refused; a refused instruction changes nothing.

The outcome of the last instruction is held in a small state machine:

- `ST_IDLE`: no matching instruction was offered.
- `ST_SKIP`: the condition failed.
- `ST_READ`: a read completed.
- `ST_WRITE`: a write completed.
- `ST_FAULT`: the instruction was refused.

Each edge moves to whichever state describes the instruction presented in that cycle, from any state.

Top module: `psr_xfer_unit`

## Requirements
- R1: After reset the live status word reads 0x000000D3 (supervisor mode, I and F set), every saved word reads zero, and `rf_we` and `illegal` are low.
- R2: A read is recognised when bits [27:23]=00010, bits [21:16]=001111 and bits [11:0]=0. Bit 22 picks the word (0 live, 1 saved for the current mode) and bits [15:12] name the destination. One cycle later `rf_we` is high, `rf_waddr` holds the destination and `rf_wdata` holds the word.
- R3: Bits [31:28] hold a condition code with flags N=bit31, Z=bit30, C=bit29 and V=bit28. The codes 0 to 15 test, in order: Z, !Z, C, !C, N, !N, V, !V, C&!Z, !C|Z, N==V, N!=V, !Z&(N==V), Z|(N!=V), always, never. A failed condition has no effect.
- R4: A flags-only write is recognised when bits [27:26]=00, bits [24:23]=10 and bits [21:12]=1010001111, with bit 22 picking the target word. When bit 25 is 1, the operand is bits [7:0] zero-extended and rotated right by twice bits [11:8].
- R5: In the register form of the flags-only write (bit 25 = 0), bits [11:4] must be zero and bits [3:0] name the source. In both forms, operand bits [31:28] replace bits [31:28] of the target, and all other bits stay unchanged.
- R6: A full write is recognised when bits [27:23]=00010, bits [21:12]=1010011111 and bits [11:4]=0, with bits [3:0] naming the source. In a privileged mode it replaces bits [31:28] and [7:0]; the reserved bits [27:8] always read zero.
- R7: In user mode (10000), a full write to the live word changes only bits [31:28].
- R8: The saved words are banked per mode: FIQ 10001, IRQ 10010, supervisor 10011, abort 10111 and undefined 11011. Each mode sees only its own word.
- R9: Accessing a saved word in user mode or system mode (11111) raises `illegal` and changes nothing.
- R10: Naming register 15 as a destination or a source raises `illegal` and performs no transfer.
- R11: A privileged full write to the live word that would change the T bit (bit 5) raises `illegal` and leaves the word unchanged.
- R12: A word that matches none of the three shapes, or any word while `instr_valid` is low, has no effect.
- R13: `src_idx` always equals instruction bits [3:0], with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction word is valid this cycle |
| instr | input | 32 | Instruction word |
| src_val | input | 32 | Value of the general register named by `src_idx` |
| src_idx | output | 4 | Source register index for the register file |
| rf_we | output | 1 | General register write enable (read result) |
| rf_waddr | output | 4 | General register destination index |
| rf_wdata | output | 32 | Status word being returned |
| illegal | output | 1 | One-cycle pulse for a refused instruction |

## Verification
The assertions assume three things about the inputs: `instr_valid` is low while reset is asserted, the mode field is only ever loaded with one of the seven listed encodings, and the live T bit starts at zero. The stimulus honours all three. It releases reset with `instr_valid` low, changes mode only through full writes that carry a listed mode value with bit 5 clear, and enters user mode last, because user mode cannot leave again. Inputs change on the falling edge and are withdrawn right after each rising edge, so every accepted instruction executes exactly once.

// File: rtl/psr_pkg.sv
package psr_pkg;

    localparam int unsigned PSR_W    = 32;
    localparam int unsigned REG_IDX_W = 4;
    localparam int unsigned MODE_W   = 5;
    localparam int unsigned T_BIT    = 5;

    localparam logic [PSR_W-1:0] FLAG_MASK = 32'hF000_0000;
    localparam logic [PSR_W-1:0] DEF_MASK  = 32'hF000_00FF;

    localparam logic [MODE_W-1:0] MD_USR = 5'b10000;
    localparam logic [MODE_W-1:0] MD_FIQ = 5'b10001;
    localparam logic [MODE_W-1:0] MD_IRQ = 5'b10010;
    localparam logic [MODE_W-1:0] MD_SVC = 5'b10011;
    localparam logic [MODE_W-1:0] MD_ABT = 5'b10111;
    localparam logic [MODE_W-1:0] MD_UND = 5'b11011;
    localparam logic [MODE_W-1:0] MD_SYS = 5'b11111;

    localparam logic [REG_IDX_W-1:0] PC_IDX = 4'hF;

    typedef enum logic [1:0] {
        K_NONE,
        K_READ,
        K_FULL,
        K_FLAG
    } xfer_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SKIP,
        ST_READ,
        ST_WRITE,
        ST_FAULT
    } xfer_state_e;

endpackage

// File: rtl/psr_cond.sv
module psr_cond
    import psr_pkg::*;
(
    input  logic [3:0] cond,
    input  logic [3:0] flags,
    output logic       pass
);

    logic n_f, z_f, c_f, v_f;

    always_comb begin
        n_f = flags[3];
        z_f = flags[2];
        c_f = flags[1];
        v_f = flags[0];
        pass = 1'b0;
        unique case (cond)
            4'h0: pass = z_f;
            4'h1: pass = !z_f;
            4'h2: pass = c_f;
            4'h3: pass = !c_f;
            4'h4: pass = n_f;
            4'h5: pass = !n_f;
            4'h6: pass = v_f;
            4'h7: pass = !v_f;
            4'h8: pass = c_f && !z_f;
            4'h9: pass = !c_f || z_f;
            4'hA: pass = (n_f == v_f);
            4'hB: pass = (n_f != v_f);
            4'hC: pass = !z_f && (n_f == v_f);
            4'hD: pass = z_f || (n_f != v_f);
            4'hE: pass = 1'b1;
            4'hF: pass = 1'b0;
        endcase
    end

endmodule

// File: rtl/psr_decode.sv
module psr_decode
    import psr_pkg::*;
(
    input  logic [PSR_W-1:0]     instr,
    output xfer_kind_e           kind,
    output logic                 sel_saved,
    output logic                 imm_op,
    output logic [REG_IDX_W-1:0] rd_idx,
    output logic [REG_IDX_W-1:0] rm_idx,
    output logic [PSR_W-1:0]     imm_val
);

    localparam int unsigned ROT_W = 4;
    localparam int unsigned AMT_W = ROT_W + 1;

    logic             is_read;
    logic             is_full;
    logic             is_flag;
    logic [PSR_W-1:0] imm_ext;
    logic [AMT_W-1:0] rot_amt;

    always_comb begin
        is_read = (instr[27:23] == 5'b00010) && (instr[21:16] == 6'b001111)
                  && (instr[11:0] == 12'h000);
        is_full = (instr[27:23] == 5'b00010) && (instr[21:12] == 10'b1010011111)
                  && (instr[11:4] == 8'h00);
        is_flag = (instr[27:26] == 2'b00) && (instr[24:23] == 2'b10)
                  && (instr[21:12] == 10'b1010001111)
                  && (instr[25] || (instr[11:4] == 8'h00));

        if (is_read)      kind = K_READ;
        else if (is_full) kind = K_FULL;
        else if (is_flag) kind = K_FLAG;
        else              kind = K_NONE;

        sel_saved = instr[22];
        imm_op    = is_flag && instr[25];
        rd_idx    = instr[15:12];
        rm_idx    = instr[3:0];

        imm_ext = {{(PSR_W-8){1'b0}}, instr[7:0]};
        rot_amt = {instr[11:8], 1'b0};
        imm_val = (imm_ext >> rot_amt) | (imm_ext << (PSR_W - rot_amt));
    end

endmodule

// File: rtl/psr_bank.sv
module psr_bank
    import psr_pkg::*;
#(
    parameter int unsigned    NBANK   = 5,
    parameter logic [PSR_W-1:0] RST_PSR = 32'h0000_00D3,
    localparam int unsigned   BIDX_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cur_we,
    input  logic [PSR_W-1:0]  cur_wmask,
    input  logic [PSR_W-1:0]  cur_wdata,
    input  logic              sav_we,
    input  logic [BIDX_W-1:0] sav_idx,
    input  logic [PSR_W-1:0]  sav_wmask,
    input  logic [PSR_W-1:0]  sav_wdata,
    output logic [PSR_W-1:0]  cur_q,
    output logic [PSR_W-1:0]  sav_q
);

    logic [PSR_W-1:0] bank_q [NBANK];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= RST_PSR;
        end else if (cur_we) begin
            cur_q <= (cur_q & ~cur_wmask) | (cur_wdata & cur_wmask);
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[b] <= '0;
            end else if (sav_we && (sav_idx == BIDX_W'(b))) begin
                bank_q[b] <= (bank_q[b] & ~sav_wmask) | (sav_wdata & sav_wmask);
            end
        end
    end

    always_comb begin
        sav_q = '0;
        for (int b = 0; b < NBANK; b++) begin
            if (sav_idx == BIDX_W'(b)) sav_q = bank_q[b];
        end
    end

endmodule

// File: rtl/psr_xfer_unit.sv
module psr_xfer_unit
    import psr_pkg::*;
#(
    parameter int unsigned      NBANK   = 5,
    parameter logic [PSR_W-1:0] RST_PSR = 32'h0000_00D3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 instr_valid,
    input  logic [PSR_W-1:0]     instr,
    input  logic [PSR_W-1:0]     src_val,
    output logic [REG_IDX_W-1:0] src_idx,
    output logic                 rf_we,
    output logic [REG_IDX_W-1:0] rf_waddr,
    output logic [PSR_W-1:0]     rf_wdata,
    output logic                 illegal
);

    localparam int unsigned BIDX_W = (NBANK > 1) ? $clog2(NBANK) : 1;

    xfer_kind_e           kind;
    logic                 sel_saved;
    logic                 imm_op;
    logic [REG_IDX_W-1:0] rd_idx;
    logic [REG_IDX_W-1:0] rm_idx;
    logic [PSR_W-1:0]     imm_val;
    logic                 cond_ok;
    logic [PSR_W-1:0]     cpsr_q;
    logic [PSR_W-1:0]     spsr_rd;

    logic                 has_bank;
    logic [BIDX_W-1:0]    bank_idx;
    logic                 privileged;
    logic [PSR_W-1:0]     operand;
    logic                 fault;
    logic                 go;
    logic                 cur_we, sav_we;
    logic [PSR_W-1:0]     wmask;
    logic [PSR_W-1:0]     rd_val;

    xfer_state_e          state_q, state_d;
    logic [REG_IDX_W-1:0] wb_addr_q;
    logic [PSR_W-1:0]     wb_data_q;

    psr_decode u_decode (
        .instr     (instr),
        .kind      (kind),
        .sel_saved (sel_saved),
        .imm_op    (imm_op),
        .rd_idx    (rd_idx),
        .rm_idx    (rm_idx),
        .imm_val   (imm_val)
    );

    psr_cond u_cond (
        .cond  (instr[31:28]),
        .flags (cpsr_q[31:28]),
        .pass  (cond_ok)
    );

    // Bank selection from the current mode field.
    always_comb begin
        has_bank = 1'b1;
        bank_idx = '0;
        case (cpsr_q[MODE_W-1:0])
            MD_FIQ:  bank_idx = BIDX_W'(0);
            MD_IRQ:  bank_idx = BIDX_W'(1);
            MD_SVC:  bank_idx = BIDX_W'(2);
            MD_ABT:  bank_idx = BIDX_W'(3);
            MD_UND:  bank_idx = BIDX_W'(4);
            default: has_bank = 1'b0;
        endcase
        privileged = (cpsr_q[MODE_W-1:0] != MD_USR);
    end

    // Operand choice, refusal checks and write masks.
    always_comb begin
        operand = imm_op ? imm_val : src_val;

        fault = 1'b0;
        if (sel_saved && !has_bank) fault = 1'b1;
        if ((kind == K_READ) && (rd_idx == PC_IDX)) fault = 1'b1;
        if ((kind == K_FULL) && (rm_idx == PC_IDX)) fault = 1'b1;
        if ((kind == K_FLAG) && !imm_op && (rm_idx == PC_IDX)) fault = 1'b1;
        if ((kind == K_FULL) && !sel_saved && privileged
            && (operand[T_BIT] != cpsr_q[T_BIT])) fault = 1'b1;

        go = instr_valid && (kind != K_NONE) && cond_ok;

        if (kind == K_FULL && (sel_saved || privileged)) wmask = DEF_MASK;
        else                                             wmask = FLAG_MASK;

        cur_we = go && !fault && (kind != K_READ) && !sel_saved;
        sav_we = go && !fault && (kind != K_READ) && sel_saved;

        rd_val = sel_saved ? spsr_rd : cpsr_q;
    end

    psr_bank #(
        .NBANK   (NBANK),
        .RST_PSR (RST_PSR)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_we    (cur_we),
        .cur_wmask (wmask),
        .cur_wdata (operand),
        .sav_we    (sav_we),
        .sav_idx   (bank_idx),
        .sav_wmask (wmask),
        .sav_wdata (operand),
        .cur_q     (cpsr_q),
        .sav_q     (spsr_rd)
    );

    // Next-state selection.
    always_comb begin
        if (!instr_valid || (kind == K_NONE)) state_d = ST_IDLE;
        else if (!cond_ok)                    state_d = ST_SKIP;
        else if (fault)                       state_d = ST_FAULT;
        else if (kind == K_READ)              state_d = ST_READ;
        else                                  state_d = ST_WRITE;
    end

    // State register with captured read-back.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            wb_addr_q <= '0;
            wb_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_READ) begin
                wb_addr_q <= rd_idx;
                wb_data_q <= rd_val;
            end
        end
    end

    // Outputs from the state.
    always_comb begin
        rf_we    = 1'b0;
        rf_waddr = '0;
        rf_wdata = '0;
        illegal  = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_SKIP, ST_WRITE: ;
            ST_READ: begin
                rf_we    = 1'b1;
                rf_waddr = wb_addr_q;
                rf_wdata = wb_data_q;
            end
            ST_FAULT: illegal = 1'b1;
            default: ;
        endcase
    end

    assign src_idx = instr[3:0];

endmodule

// File: rtl/psr_xfer_chk.sv
module psr_xfer_chk
    import psr_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 instr_valid,
    input logic                 sel_bit,
    input logic                 rf_we,
    input logic [REG_IDX_W-1:0] rf_waddr,
    input logic                 illegal,
    input logic [27:0]          cpsr_lo
);

    // R2
    read_vs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> !illegal);

    // R12
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |=> (!rf_we && !illegal));

    // R10
    no_pc_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> (rf_waddr != PC_IDX));

    // R9
    no_saved_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && sel_bit && ((cpsr_lo[4:0] == MD_USR) || (cpsr_lo[4:0] == MD_SYS)))
        |=> !rf_we);

    // R7
    user_ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpsr_lo[4:0] == MD_USR) |=> (cpsr_lo == $past(cpsr_lo)));

    // R11
    t_bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (cpsr_lo[T_BIT] == $past(cpsr_lo[T_BIT])));

    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpsr_lo[27:8] == 20'h0);

endmodule

bind psr_xfer_unit psr_xfer_chk u_psr_xfer_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_valid (instr_valid),
    .sel_bit     (instr[22]),
    .rf_we       (rf_we),
    .rf_waddr    (rf_waddr),
    .illegal     (illegal),
    .cpsr_lo     (cpsr_q[27:0])
);

// File: tb/test_psr_xfer_unit.sv
module test_psr_xfer_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_val = '0;
    logic [3:0]  src_idx;
    logic        rf_we;
    logic [3:0]  rf_waddr;
    logic [31:0] rf_wdata;
    logic        illegal;

    int n_tests = 0;
    int n_fail = 0;
    bit done = 0;

    logic        o_we, o_ill;
    logic [3:0]  o_addr;
    logic [31:0] o_data;
    logic [31:0] m_cpsr;
    logic [31:0] rv;

    always #5 clk = ~clk;

    psr_xfer_unit i_psr_xfer_unit (
        .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid), .instr (instr),
        .src_val (src_val), .src_idx (src_idx), .rf_we (rf_we),
        .rf_waddr (rf_waddr), .rf_wdata (rf_wdata), .illegal (illegal)
    );

    localparam logic [3:0] AL = 4'hE;
    localparam logic [3:0] NV = 4'hF;
    localparam logic [31:0] DEFM = 32'hF000_00FF;

    function automatic logic [31:0] enc_rd(logic [3:0] c, logic s, logic [3:0] rd);
        return {c, 5'b00010, s, 6'b001111, rd, 12'h000};
    endfunction
    function automatic logic [31:0] enc_wr(logic [3:0] c, logic s, logic [3:0] rm);
        return {c, 5'b00010, s, 10'b1010011111, 8'h00, rm};
    endfunction
    function automatic logic [31:0] enc_fr(logic [3:0] c, logic s, logic [3:0] rm);
        return {c, 2'b00, 1'b0, 2'b10, s, 10'b1010001111, 8'h00, rm};
    endfunction
    function automatic logic [31:0] enc_fi(logic [3:0] c, logic s, logic [3:0] rot, logic [7:0] imm);
        return {c, 2'b00, 1'b1, 2'b10, s, 10'b1010001111, rot, imm};
    endfunction

    function automatic logic cond_model(logic [3:0] c, logic [3:0] f);
        logic n, z, cc, v, r;
        n = f[3]; z = f[2]; cc = f[1]; v = f[0];
        case (c)
            4'h0: r = z;          4'h1: r = !z;
            4'h2: r = cc;         4'h3: r = !cc;
            4'h4: r = n;          4'h5: r = !n;
            4'h6: r = v;          4'h7: r = !v;
            4'h8: r = cc && !z;   4'h9: r = !cc || z;
            4'hA: r = (n == v);   4'hB: r = (n != v);
            4'hC: r = !z && (n == v);
            4'hD: r = z || (n != v);
            4'hE: r = 1'b1;       default: r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] ror_imm(logic [7:0] imm, logic [3:0] rot);
        logic [31:0] x;
        x = {24'h0, imm};
        for (int k = 0; k < 2 * int'(rot); k++) x = {x[0], x[31:1]};
        return x;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic issue(logic [31:0] ins, logic [31:0] sv);
        @(negedge clk);
        instr = ins; src_val = sv; instr_valid = 1'b1;
        @(posedge clk);
        #1;
        o_we = rf_we; o_addr = rf_waddr; o_data = rf_wdata; o_ill = illegal;
        instr_valid = 1'b0;
    endtask

    task automatic rd_psr(logic s, output logic [31:0] v);
        issue(enc_rd(AL, s, 4'd1), 32'h0);
        v = o_data;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] imms [3];
        logic [4:0] modes [6];
        imms[0] = 8'hA5; imms[1] = 8'h3C; imms[2] = 8'hF1;
        modes[0] = 5'b10001; modes[1] = 5'b10010; modes[2] = 5'b10011;
        modes[3] = 5'b10111; modes[4] = 5'b11011; modes[5] = 5'b11111;

        repeat (3) @(posedge clk);
        #1;
        chk("R1 we after reset", {31'h0, rf_we}, 32'h0);
        chk("R1 illegal after reset", {31'h0, illegal}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        rd_psr(1'b0, rv);
        chk("R1 live word reset", rv, 32'h0000_00D3);
        m_cpsr = 32'h0000_00D3;
        rd_psr(1'b1, rv);
        chk("R1 saved word reset", rv, 32'h0);

        // R13: source index follows the instruction combinationally
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            instr = {28'h0123456, 4'(i)};
            #1;
            chk("R13 src_idx", {28'h0, src_idx}, 32'(i));
        end

        // R2: read returns destination and data
        issue(enc_rd(AL, 1'b0, 4'd7), 32'h0);
        chk("R2 we", {31'h0, o_we}, 32'h1);
        chk("R2 addr", {28'h0, o_addr}, 32'h7);
        chk("R2 data", o_data, m_cpsr);

        // R3: all conditions against all flag values
        for (int f = 0; f < 16; f++) begin
            issue(enc_fi(AL, 1'b0, 4'd4, {4'(f), 4'h0}), 32'h0);
            m_cpsr = {4'(f), m_cpsr[27:0]};
            for (int c = 0; c < 16; c++) begin
                issue(enc_rd(4'(c), 1'b0, 4'd3), 32'h0);
                chk("R3 condition", {31'h0, o_we}, {31'h0, cond_model(4'(c), 4'(f))});
            end
        end

        // R4: rotated immediate sweep
        for (int r = 0; r < 16; r++) begin
            for (int k = 0; k < 3; k++) begin
                issue(enc_fi(AL, 1'b0, 4'(r), imms[k]), 32'h0);
                m_cpsr = {ror_imm(imms[k], 4'(r)) >> 28, 28'h0} | (m_cpsr & 32'h0FFF_FFFF);
                m_cpsr = (ror_imm(imms[k], 4'(r)) & 32'hF000_0000) | (m_cpsr & 32'h0FFF_FFFF);
                rd_psr(1'b0, rv);
                chk("R4 rotated immediate", rv, m_cpsr);
            end
        end

        // R5: register-form flag write to live and saved words
        issue(enc_fr(AL, 1'b0, 4'd2), 32'h9FFF_FFFF);
        m_cpsr = {4'h9, m_cpsr[27:0]};
        rd_psr(1'b0, rv);
        chk("R5 flag reg live", rv, m_cpsr);
        issue(enc_fr(AL, 1'b1, 4'd2), 32'h9123_4567);
        rd_psr(1'b1, rv);
        chk("R5 flag reg saved", rv, 32'h9000_0000);

        // R6 R8 R9: visit each privileged mode
        for (int i = 0; i < 6; i++) begin
            issue(enc_wr(AL, 1'b0, 4'd2), 32'h0ABC_0000 | 32'hC0 | 32'(modes[i]));
            m_cpsr = (32'hC0 | 32'(modes[i]));
            chk("R6 mode switch", {31'h0, o_ill}, 32'h0);
            rd_psr(1'b0, rv);
            chk("R6 live word masked", rv, m_cpsr);
            issue(enc_wr(AL, 1'b1, 4'd4), 32'h5ABC_DE00 | 32'(i + 1));
            if (i == 5) begin
                chk("R9 saved write in system", {31'h0, o_ill}, 32'h1);
                rd_psr(1'b1, rv);
                chk("R9 saved read in system", {30'h0, o_we, o_ill}, 32'h1);
            end else begin
                chk("R8 saved write ok", {31'h0, o_ill}, 32'h0);
                rd_psr(1'b1, rv);
                chk("R8 saved read back", rv, (32'h5ABC_DE00 | 32'(i + 1)) & DEFM);
            end
        end
        for (int i = 0; i < 5; i++) begin
            issue(enc_wr(AL, 1'b0, 4'd2), 32'hC0 | 32'(modes[i]));
            rd_psr(1'b1, rv);
            chk("R8 bank kept", rv, 32'h5000_0000 | 32'(i + 1));
        end
        m_cpsr = 32'hC0 | 32'(modes[4]);

        // R10: register 15
        issue(enc_rd(AL, 1'b0, 4'hF), 32'h0);
        chk("R10 read to r15", {30'h0, o_we, o_ill}, 32'h1);
        issue(enc_wr(AL, 1'b0, 4'hF), 32'hF000_00D3);
        chk("R10 full from r15", {31'h0, o_ill}, 32'h1);
        issue(enc_fr(AL, 1'b0, 4'hF), 32'hF000_0000);
        chk("R10 flag from r15", {31'h0, o_ill}, 32'h1);
        rd_psr(1'b0, rv);
        chk("R10 live word unchanged", rv, m_cpsr);

        // R11: T bit change refused
        issue(enc_wr(AL, 1'b0, 4'd2), m_cpsr | 32'h20);
        chk("R11 T change flagged", {31'h0, o_ill}, 32'h1);
        rd_psr(1'b0, rv);
        chk("R11 live word unchanged", rv, m_cpsr);

        // R12: non-matching words and invalid strobe
        issue(enc_rd(AL, 1'b0, 4'd1) | 32'h1, 32'h0);
        chk("R12 malformed read", {30'h0, o_we, o_ill}, 32'h0);
        issue(enc_wr(AL, 1'b0, 4'd2) | 32'h0000_0100, 32'hF000_00DB);
        chk("R12 malformed write", {30'h0, o_we, o_ill}, 32'h0);
        issue(enc_fi(NV, 1'b0, 4'd4, 8'hF0), 32'h0);
        @(negedge clk);
        instr = enc_fi(AL, 1'b0, 4'd4, 8'hF0); instr_valid = 1'b0;
        @(posedge clk);
        #1;
        chk("R12 strobe low", {30'h0, rf_we, illegal}, 32'h0);
        rd_psr(1'b0, rv);
        chk("R12 live word unchanged", rv, m_cpsr);

        // R7 R9: user mode
        issue(enc_wr(AL, 1'b0, 4'd2), 32'h0000_0010);
        m_cpsr = 32'h0000_0010;
        issue(enc_wr(AL, 1'b0, 4'd2), 32'hA000_00D3);
        chk("R7 user full write ok", {31'h0, o_ill}, 32'h0);
        m_cpsr = 32'hA000_0010;
        rd_psr(1'b0, rv);
        chk("R7 user full write flags only", rv, m_cpsr);
        issue(enc_fr(AL, 1'b0, 4'd2), 32'h5FFF_FFFF);
        m_cpsr = 32'h5000_0010;
        rd_psr(1'b0, rv);
        chk("R7 user flag write", rv, m_cpsr);
        rd_psr(1'b1, rv);
        chk("R9 user saved read", {30'h0, o_we, o_ill}, 32'h1);
        issue(enc_wr(AL, 1'b1, 4'd2), 32'hF000_00D3);
        chk("R9 user saved write", {31'h0, o_ill}, 32'h1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule